// File: doc/BRIEF.md
# Repeated Byte-Move Engine

This block carries out a whole memory-to-memory byte copy in response to one issued command. Before the command, software fills three implicit registers: a source pointer, a destination pointer and a byte count. The command itself is two bytes long. A repeat-prefix byte must come first, and the byte-move opcode must follow it directly. The copy is one instruction executed again and again, not a loop of instructions. Each pass reads one byte at the source pointer, writes it at the destination pointer, moves both pointers by one and lowers the count by one. The run ends when the count reaches zero.

The three registers are architectural state. They are visible on the ports at all times, and the engine updates them as the copy runs. When the copy ends, both pointers have moved by the original count and the count reads zero. A direction input is sampled when the command starts. If it is set, the pointers step downward instead of upward.

Memory is reached through three channels, each with valid/ready handshakes: a read-request channel, a read-response channel and a write channel. A request stays valid, with its address and data unchanged, until the memory side raises ready. At most one read is outstanding at a time. The read response is taken whenever it is valid and cannot be back-pressured. The memory side may stall either request channel for any number of cycles.

Top module: `rsm_top`

## Requirements
- R1: A copy starts only when command byte 0xA4 is accepted and the command byte accepted just before it was 0xF2. A 0xF2 followed by 0xF2 keeps the prefix armed. Any other byte, or an 0xA4 with no prefix in front of it, starts nothing.
- R2: Each pass issues one read at the current source pointer. It then writes the returned byte at the current destination pointer. Passes run strictly one after another, so an overlapping forward copy repeats the first source bytes along the destination.
- R3: After each accepted write, both pointers step by one and the count drops by one. The pointers step up when the direction latched at start is 0 and down when it is 1. At the end the pointers equal their start values plus or minus the original count, and the count is zero.
- R4: A start with a count of zero raises done in the next cycle and issues no read or write.
- R5: Busy is high from the cycle after a start with a nonzero count until the final write is accepted. Done is high for exactly one cycle, the cycle after that final write, and busy is low in that cycle.
- R6: Command bytes that arrive while busy is high are ignored and do not arm the prefix. Changes to the direction input while busy have no effect on the running copy.
- R7: A register write uses select 0 for the source pointer, 1 for the destination pointer and 2 for the count; select 3 writes nothing. The write is ignored while busy is high and in the cycle a start is accepted.
- R8: Read and write requests hold valid, address and data steady until ready is seen. The two requests are never valid in the same cycle.
- R9: After reset all three registers are zero, busy and done are low, and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (0 source, 1 destination, 2 count) |
| reg_wr_data | input | ADDR_W | Register write value |
| dir_dec | input | 1 | Direction: 0 step up, 1 step down (sampled at start) |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| src_ptr | output | ADDR_W | Live source pointer |
| dst_ptr | output | ADDR_W | Live destination pointer |
| count_left | output | ADDR_W | Live remaining count |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read address |
| rresp_valid | input | 1 | Read data returned |
| rresp_data | input | 8 | Returned byte |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write byte |

## Verification
The copy is run with short, single-byte and longer counts, in both directions, and with and without stalls from the memory side. This shows that the step direction, the loop ending and the request hold rules behave the same whether or not the memory stalls. One case has source and destination one pattern period apart and overlapping. Its result matches only if the passes run strictly in order, one byte at a time. Further command streams check the prefix rule: a lone opcode, a prefix broken by another byte, and a repeated prefix. Stimulus sent during a run checks that commands, register writes and direction changes are ignored while the engine is busy.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  localparam logic [7:0] CMD_REP_PREFIX = 8'hF2;
  localparam logic [7:0] CMD_MOVE_BYTE  = 8'hA4;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR      = 2'd3
  } seq_state_t;

endpackage

// File: rtl/rsm_cmd_decode.sv
module rsm_cmd_decode
  import rsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       busy,
  output logic       start_o
);

  logic pref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pref_q <= 1'b0;
    end else if (busy) begin
      pref_q <= 1'b0;
    end else if (cmd_valid) begin
      pref_q <= (cmd_byte == CMD_REP_PREFIX);
    end
  end

  assign start_o = !busy && cmd_valid && pref_q && (cmd_byte == CMD_MOVE_BYTE);

  // R1
  lone_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte != CMD_REP_PREFIX) |=> !start_o);

  // R6
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_o);

endmodule

// File: rtl/rsm_regs.sv
module rsm_regs
  import rsm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              busy,
  input  logic              start,
  input  logic              dir_in,
  input  logic              step,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] cnt_q,
  output logic              cnt_zero,
  output logic              cnt_last
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              dir_q;
  logic              wr_ok;
  logic [ADDR_W-1:0] ptr_delta;

  assign wr_ok     = wr_en && !busy && !start;
  assign ptr_delta = dir_q ? {ADDR_W{1'b1}} : ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      if (start) begin
        dir_q <= dir_in;
      end
      if (step) begin
        src_q <= src_q + ptr_delta;
        dst_q <= dst_q + ptr_delta;
        cnt_q <= cnt_q - ONE;
      end else if (wr_ok) begin
        unique case (reg_sel_t'(wr_sel))
          SEL_SRC: src_q <= wr_data;
          SEL_DST: dst_q <= wr_data;
          SEL_CNT: cnt_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == ONE);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) - ONE));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

endmodule

// File: rtl/rsm_seq.sv
module rsm_seq
  import rsm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cnt_zero,
  input  logic              cnt_last,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rresp_valid,
  input  logic [7:0]        rresp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              step,
  output logic              busy,
  output logic              done
);

  seq_state_t state_q, state_d;
  logic [7:0] byte_q;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cnt_zero) done_d  = 1'b1;
          else          state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        if (rd_ready) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (rresp_valid) state_d = ST_WR;
      end
      ST_WR: begin
        if (wr_ready) begin
          step = 1'b1;
          if (cnt_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_RD_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (state_q == ST_RD_WAIT && rresp_valid) begin
        byte_q <= rresp_data;
      end
    end
  end

  assign rd_valid = (state_q == ST_RD_REQ);
  assign rd_addr  = src;
  assign wr_valid = (state_q == ST_WR);
  assign wr_addr  = dst;
  assign wr_data  = byte_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cnt_zero) |=> (done && !busy && !rd_valid));

endmodule

// File: rtl/rsm_top.sv
module rsm_top
  import rsm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [ADDR_W-1:0] reg_wr_data,
  input  logic              dir_dec,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [ADDR_W-1:0] count_left,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rresp_valid,
  input  logic [7:0]        rresp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic start;
  logic step;
  logic cnt_zero;
  logic cnt_last;

  rsm_cmd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .busy      (busy),
    .start_o   (start)
  );

  rsm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_sel   (reg_wr_sel),
    .wr_data  (reg_wr_data),
    .busy     (busy),
    .start    (start),
    .dir_in   (dir_dec),
    .step     (step),
    .src_q    (src_ptr),
    .dst_q    (dst_ptr),
    .cnt_q    (count_left),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last)
  );

  rsm_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cnt_zero    (cnt_zero),
    .cnt_last    (cnt_last),
    .src         (src_ptr),
    .dst         (dst_ptr),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr),
    .rresp_valid (rresp_valid),
    .rresp_data  (rresp_data),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .step        (step),
    .busy        (busy),
    .done        (done)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !rd_valid && !wr_valid && count_left == '0));

endmodule

// File: tb/rsm_top_tb.sv
`timescale 1ns/1ps
module rsm_top_tb_top;

  localparam int AW = 16;

  typedef struct packed {
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] cnt;
    logic        dir;
    logic        stall;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{src: 16'h0010, dst: 16'h0080, cnt: 16'd5,  dir: 1'b0, stall: 1'b0},
    '{src: 16'h0020, dst: 16'h0090, cnt: 16'd1,  dir: 1'b0, stall: 1'b1},
    '{src: 16'h004F, dst: 16'h00CF, cnt: 16'd8,  dir: 1'b1, stall: 1'b0},
    '{src: 16'h0030, dst: 16'h0033, cnt: 16'd6,  dir: 1'b0, stall: 1'b1},
    '{src: 16'h0060, dst: 16'h00A0, cnt: 16'd12, dir: 1'b0, stall: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_wr_sel = 2'd3;
  logic [AW-1:0] reg_wr_data = '0;
  logic          dir_dec = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_byte = '0;
  logic [AW-1:0] src_ptr, dst_ptr, count_left;
  logic          busy, done;
  logic          rd_valid, rd_ready, rresp_valid;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rresp_data, wr_data;
  logic          wr_valid, wr_ready;

  rsm_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .dir_dec(dir_dec), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .count_left(count_left), .busy(busy), .done(done), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rresp_valid(rresp_valid),
    .rresp_data(rresp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // memory model
  logic [7:0] mem   [256];
  logic [7:0] model [256];
  logic       init_mem = 1'b0;
  logic       stall_en = 1'b0;
  int         cyc = 0;
  int         n_rd = 0;
  int         n_wr = 0;
  int         n_done = 0;

  assign rd_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
  assign wr_ready = stall_en ? (cyc % 4 != 1) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) n_done <= n_done + 1;
    if (init_mem) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
      rresp_valid <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) begin
        rresp_valid <= 1'b1;
        rresp_data  <= mem[rd_addr[7:0]];
        n_rd <= n_rd + 1;
      end else begin
        rresp_valid <= 1'b0;
      end
      if (wr_valid && wr_ready) begin
        mem[wr_addr[7:0]] <= wr_data;
        n_wr <= n_wr + 1;
      end
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_reg(input logic [1:0] sel, input logic [AW-1:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_sel = 2'd3;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic reset_mem();
    @(negedge clk); init_mem = 1'b1;
    @(negedge clk); init_mem = 1'b0;
    for (int i = 0; i < 256; i++) model[i] = 8'(i * 37 + 11);
  endtask

  task automatic model_copy(input vec_t v);
    for (int k = 0; k < int'(v.cnt); k++) begin
      logic [15:0] s, d;
      s = v.dir ? v.src - 16'(k) : v.src + 16'(k);
      d = v.dir ? v.dst - 16'(k) : v.dst + 16'(k);
      model[d[7:0]] = model[s[7:0]];
    end
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(req, {31'd0, done}, 32'd1);
  endtask

  task automatic check_mem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 busy", {31'd0, busy}, 0);
    chk("R9 done", {31'd0, done}, 0);
    chk("R9 req", {30'd0, rd_valid, wr_valid}, 0);
    chk("R9 regs", {src_ptr, count_left}, 0);
    rst_n = 1'b1;
    reset_mem();

    // table of copy vectors: R2, R3, R5, R8
    for (int vi = 0; vi < NV; vi++) begin
      vec_t v;
      int r0, w0;
      v = VECS[vi];
      reset_mem();
      model_copy(v);
      stall_en = v.stall;
      load_reg(2'd0, v.src);
      load_reg(2'd1, v.dst);
      load_reg(2'd2, v.cnt);
      dir_dec = v.dir;
      r0 = n_rd; w0 = n_wr;
      send_byte(8'hF2);
      send_byte(8'hA4);
      chk("R5 busy after start", {31'd0, busy}, 1);
      wait_done("R5 done seen");
      chk("R5 busy low at done", {31'd0, busy}, 0);
      @(negedge clk);
      chk("R5 done one cycle", {31'd0, done}, 0);
      chk("R3 src final", 32'(src_ptr), 32'(v.dir ? v.src - v.cnt : v.src + v.cnt));
      chk("R3 dst final", 32'(dst_ptr), 32'(v.dir ? v.dst - v.cnt : v.dst + v.cnt));
      chk("R3 count final", 32'(count_left), 0);
      chk("R2 read count", 32'(n_rd - r0), 32'(v.cnt));
      chk("R2 write count", 32'(n_wr - w0), 32'(v.cnt));
      check_mem("R2 memory image");
      stall_en = 1'b0;
      dir_dec = 1'b0;
    end

    // R4: zero count
    begin
      int r0, d0;
      load_reg(2'd2, 16'd0);
      r0 = n_rd; d0 = n_done;
      send_byte(8'hF2);
      send_byte(8'hA4);
      chk("R4 done next cycle", {30'd0, done, busy}, 32'h2);
      @(negedge clk);
      chk("R4 no access", 32'(n_rd - r0), 0);
      chk("R4 single done", 32'(n_done - d0), 1);
    end

    // R1: prefix rule, count zero so a start shows as a done pulse
    begin
      int d0;
      d0 = n_done;
      send_byte(8'hA4);
      repeat (3) @(negedge clk);
      chk("R1 lone opcode", 32'(n_done - d0), 0);
      send_byte(8'hF2);
      send_byte(8'h90);
      send_byte(8'hA4);
      repeat (3) @(negedge clk);
      chk("R1 broken prefix", 32'(n_done - d0), 0);
      send_byte(8'hF2);
      send_byte(8'hF2);
      send_byte(8'hA4);
      repeat (3) @(negedge clk);
      chk("R1 repeated prefix", 32'(n_done - d0), 1);
    end

    // R6, R7: stimulus while busy
    begin
      int w0, d0;
      reset_mem();
      model_copy('{src: 16'h0005, dst: 16'h00E0, cnt: 16'd10, dir: 1'b0, stall: 1'b1});
      stall_en = 1'b1;
      load_reg(2'd0, 16'h0005);
      load_reg(2'd1, 16'h00E0);
      load_reg(2'd2, 16'd10);
      w0 = n_wr; d0 = n_done;
      send_byte(8'hF2);
      send_byte(8'hA4);
      repeat (2) @(negedge clk);
      dir_dec = 1'b1;
      send_byte(8'hF2);
      send_byte(8'hA4);
      load_reg(2'd0, 16'h0000);
      load_reg(2'd2, 16'd3);
      wait_done("R6 done seen");
      dir_dec = 1'b0;
      chk("R7 src ignores write", 32'(src_ptr), 32'h000F);
      chk("R6 dst direction kept", 32'(dst_ptr), 32'h00EA);
      check_mem("R6 memory image");
      repeat (20) @(negedge clk);
      chk("R6 no second run", 32'(n_wr - w0), 10);
      chk("R6 single done", 32'(n_done - d0), 1);
      chk("R6 idle", {31'd0, busy}, 0);
      stall_en = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule